// File: doc/BRIEF.md
# Dual-Scan Key Matrix Scanner

This block reads a key matrix of six drive lines and five sense lines, 30 key positions in all. While no key is down it does nothing but hold its drive lines at an idle pattern. In normal operation every line is high. In low-power operation only the lines that a per-line enable word selects are high. When any sense line goes high, the block walks a single high level across the drive lines, one line at a time, and captures the sense lines for each. It does this twice in succession and compares the two captures.

If both captures agree and some key is down, the block copies the data into a holding register, returns a sleep-acknowledge bit taken at the same moment, and pulls its active-low read request low. The host reads the held word and then signals that the readout is done. That signal releases the request and starts a fresh pair of scans, so a key that is still held raises a new request.

A pair of scans that disagree is thrown away and a new pair is started at once. A pair that agrees on "no key" returns the block to idle without raising a request. In low-power operation a detected key raises a wake request to the clock generator for as long as scanning runs. The low-power setting itself is never changed by the block.

Top module: `kscan_matrix`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. Afterwards `req_n_o` is 1, `key_data_o` and `sleep_ack_o` are 0, and `wake_o` is 0.
- R2: In idle, the drive lines show the idle pattern: all ones when `sleep_i` is 0, and `sleep_drive_i` when `sleep_i` is 1. No scan starts while every sense input is low. A key on an undriven line therefore starts nothing.
- R3: A scan drives exactly one line high at a time, from line 0 to line NUM_OUT-1, each for SCAN_TICKS/NUM_OUT ticks. Sense input i read while line l is driven lands in key bit l*NUM_IN+i. Bit 0 is line 0 input 0, and bit 29 is line 5 input 4.
- R4: The scan starts on the clock edge after a sense input is seen high. When both scans agree and are non-zero, `req_n_o` goes low 2*SCAN_TICKS+GAP_TICKS ticks after that start.
- R5: When the two scans differ, a new pair begins at once. The request then appears 2*(2*SCAN_TICKS+GAP_TICKS) ticks after the first start.
- R6: `req_n_o` reads 1 whenever `cs_i` is 1, even while a request is pending.
- R7: `key_data_o` and `sleep_ack_o` stay unchanged while a request is pending, whatever the keys do.
- R8: A pending request stays pending until `rd_done_i` is 1. That pulse raises `req_n_o` on the next edge and starts a new scan pair. If that pair finds no key, the block returns to idle without a request.
- R9: When `sleep_i` is 1, `wake_o` is 1 from the scan start until the return to idle. `sleep_ack_o` reports the value `sleep_i` had when the data was latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Oscillator-derived timing tick, one per period T |
| key_in_i | input | NUM_IN | Sense lines from the matrix, pulled low when open |
| sleep_i | input | 1 | Low-power operation selected |
| sleep_drive_i | input | NUM_OUT | Drive lines held high while idle in low-power operation |
| cs_i | input | 1 | Serial-port select; masks the request while high |
| rd_done_i | input | 1 | Host finished reading the key data |
| scan_o | output | NUM_OUT | Drive lines to the matrix |
| key_data_o | output | NUM_OUT*NUM_IN | Held key data |
| sleep_ack_o | output | 1 | Low-power state at the moment the data was held |
| req_n_o | output | 1 | Read request, active low |
| wake_o | output | 1 | Wake request to the clock generator |

## Verification
On every cycle, the assertions check four things. Scan lines are one-hot during a scan. Idle persists without a key. A pending request holds until readout and its data stays frozen. The hold state is entered only at the end of a matching, non-empty pair.

Some behaviour only the bench's scenarios can show. That includes the exact cycle of the request after a match or a mismatch, and the mapping of each line and input to a key bit. It also includes the chip-select mask, the silent return to idle after release, and key detection and wake in low-power operation with a partial drive pattern.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN1 = 3'd1,
        ST_SCAN2 = 3'd2,
        ST_GAP   = 3'd3,
        ST_HOLD  = 3'd4
    } kscan_state_e;

    typedef struct packed {
        logic sample;
        logic last_line;
        logic gap_done;
    } kscan_strobe_s;

    function automatic logic is_scanning(input kscan_state_e st);
        return (st == ST_SCAN1) || (st == ST_SCAN2);
    endfunction

endpackage

// File: rtl/kscan_timer.sv
module kscan_timer
    import kscan_pkg::*;
#(
    parameter int NUM_OUT    = 6,
    parameter int LINE_TICKS = 2000,
    parameter int GAP_TICKS  = 1600,
    localparam int LW        = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  kscan_state_e  state,
    output logic [LW-1:0] line_idx,
    output kscan_strobe_s strobe
);
    localparam int MAXT = (LINE_TICKS > GAP_TICKS) ? LINE_TICKS : GAP_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic          scanning;
    logic          slot_last;
    logic          gap_last;
    logic          line_last;

    assign scanning  = is_scanning(state);
    assign slot_last = (cnt == CW'(LINE_TICKS - 1));
    assign gap_last  = (cnt == CW'(GAP_TICKS - 1));
    assign line_last = (line_idx == LW'(NUM_OUT - 1));

    assign strobe.sample    = scanning && tick_i && slot_last;
    assign strobe.last_line = line_last;
    assign strobe.gap_done  = (state == ST_GAP) && tick_i && gap_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            line_idx <= '0;
        end else if (scanning) begin
            if (tick_i) begin
                if (slot_last) begin
                    cnt      <= '0;
                    line_idx <= line_last ? '0 : line_idx + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else if (state == ST_GAP) begin
            if (tick_i) begin
                cnt <= gap_last ? '0 : cnt + 1'b1;
            end
        end else begin
            cnt      <= '0;
            line_idx <= '0;
        end
    end

endmodule

// File: rtl/kscan_capture.sv
module kscan_capture
    import kscan_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int NUM_IN  = 5,
    localparam int LW     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int KW     = NUM_OUT * NUM_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  kscan_state_e      state,
    input  logic              sample,
    input  logic [LW-1:0]     line_idx,
    input  logic [NUM_IN-1:0] key_in,
    input  logic              latch_en,
    input  logic              sleep_i,
    output logic [KW-1:0]     hold_q,
    output logic              sleep_ack_q,
    output logic              match,
    output logic              any_key
);
    logic [KW-1:0] first_q;
    logic [KW-1:0] second_q;

    assign match   = (first_q == second_q);
    assign any_key = |second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q     <= '0;
            second_q    <= '0;
            hold_q      <= '0;
            sleep_ack_q <= 1'b0;
        end else begin
            if (sample) begin
                for (int l = 0; l < NUM_OUT; l++) begin
                    if (line_idx == LW'(l)) begin
                        if (state == ST_SCAN1) begin
                            first_q[l*NUM_IN +: NUM_IN] <= key_in;
                        end else begin
                            second_q[l*NUM_IN +: NUM_IN] <= key_in;
                        end
                    end
                end
            end
            if (latch_en) begin
                hold_q      <= second_q;
                sleep_ack_q <= sleep_i;
            end
        end
    end

    // R7: the held snapshot does not move while a request is pending
    a_r7_snapshot_stable: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state == ST_HOLD)) |-> ($stable(hold_q) && $stable(sleep_ack_q)));

    // R1: reset clears the held data and acknowledge bit
    a_r1_reset_clears_data: assert property (@(posedge clk)
        rst |=> (hold_q == '0 && !sleep_ack_q));

endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
    import kscan_pkg::*;
#(
    parameter int NUM_IN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] key_in,
    input  kscan_strobe_s     strobe,
    input  logic              match,
    input  logic              any_key,
    input  logic              rd_done_i,
    output kscan_state_e      state,
    output logic              latch_en
);
    kscan_state_e state_nxt;

    assign latch_en = strobe.gap_done && match && any_key;

    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE:  if (|key_in) state_nxt = ST_SCAN1;
            ST_SCAN1: if (strobe.sample && strobe.last_line) state_nxt = ST_SCAN2;
            ST_SCAN2: if (strobe.sample && strobe.last_line) state_nxt = ST_GAP;
            ST_GAP: begin
                if (strobe.gap_done) begin
                    if (!match)       state_nxt = ST_SCAN1;
                    else if (any_key) state_nxt = ST_HOLD;
                    else              state_nxt = ST_IDLE;
                end
            end
            ST_HOLD:  if (rd_done_i) state_nxt = ST_SCAN1;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // R1: reset forces idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

    // R2: without a key the block stays idle
    a_r2_idle_needs_key: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(|key_in)) |=> (state == ST_IDLE));

    // R4: the hold state follows only a matching, non-empty pair
    a_r4_hold_after_match: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) != ST_HOLD) |->
            ($past(state) == ST_GAP && $past(match) && $past(any_key)));

    // R8: a pending request is held until the readout completes
    a_r8_hold_until_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !rd_done_i) |=> (state == ST_HOLD));

endmodule

// File: rtl/kscan_matrix.sv
module kscan_matrix
    import kscan_pkg::*;
#(
    parameter int NUM_OUT    = 6,
    parameter int NUM_IN     = 5,
    parameter int SCAN_TICKS = 12000,
    parameter int GAP_TICKS  = 1600
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_i,
    input  logic [NUM_IN-1:0]         key_in_i,
    input  logic                      sleep_i,
    input  logic [NUM_OUT-1:0]        sleep_drive_i,
    input  logic                      cs_i,
    input  logic                      rd_done_i,
    output logic [NUM_OUT-1:0]        scan_o,
    output logic [NUM_OUT*NUM_IN-1:0] key_data_o,
    output logic                      sleep_ack_o,
    output logic                      req_n_o,
    output logic                      wake_o
);
    localparam int KW         = NUM_OUT * NUM_IN;
    localparam int LINE_TICKS = SCAN_TICKS / NUM_OUT;
    localparam int LW         = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

    kscan_state_e        state;
    kscan_strobe_s       strobe;
    logic [LW-1:0]       line_idx;
    logic                match;
    logic                any_key;
    logic                latch_en;
    logic [NUM_OUT-1:0]  idle_pat;
    logic                scanning;

    kscan_timer #(
        .NUM_OUT    (NUM_OUT),
        .LINE_TICKS (LINE_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .state    (state),
        .line_idx (line_idx),
        .strobe   (strobe)
    );

    kscan_capture #(
        .NUM_OUT (NUM_OUT),
        .NUM_IN  (NUM_IN)
    ) capture_i (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .sample      (strobe.sample),
        .line_idx    (line_idx),
        .key_in      (key_in_i),
        .latch_en    (latch_en),
        .sleep_i     (sleep_i),
        .hold_q      (key_data_o),
        .sleep_ack_q (sleep_ack_o),
        .match       (match),
        .any_key     (any_key)
    );

    kscan_ctrl #(
        .NUM_IN (NUM_IN)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .key_in    (key_in_i),
        .strobe    (strobe),
        .match     (match),
        .any_key   (any_key),
        .rd_done_i (rd_done_i),
        .state     (state),
        .latch_en  (latch_en)
    );

    assign scanning = is_scanning(state);
    assign idle_pat = sleep_i ? sleep_drive_i : {NUM_OUT{1'b1}};

    for (genvar l = 0; l < NUM_OUT; l++) begin : g_line
        assign scan_o[l] = scanning ? (line_idx == LW'(l)) : idle_pat[l];
    end

    assign req_n_o = (state != ST_HOLD) || cs_i;
    assign wake_o  = sleep_i && (state != ST_IDLE);

    // R3: during a scan exactly one drive line is high
    a_r3_onehot_scan: assert property (@(posedge clk) disable iff (rst)
        scanning |-> $onehot(scan_o));

endmodule

// File: tb/kscan_matrix_tb_top.sv
`timescale 1ns/1ps
module kscan_matrix_tb_top;
    localparam int NO   = 6;
    localparam int NI   = 5;
    localparam int SCAN = 12;
    localparam int GAP  = 4;
    localparam int PAIR = 2*SCAN + GAP;
    localparam int KW   = NO*NI;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic [NI-1:0] key_in;
    logic          sleep = 1'b0;
    logic [NO-1:0] sleep_drive = '0;
    logic          cs = 1'b0;
    logic          rd_done = 1'b0;
    logic [NO-1:0] scan;
    logic [KW-1:0] key_data;
    logic          sleep_ack;
    logic          req_n;
    logic          wake;

    logic [KW-1:0] pressed = '0;
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;

    typedef struct {
        logic [KW-1:0] data;
        logic          ack;
        int            at;
        string         tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kscan_matrix #(
        .NUM_OUT(NO), .NUM_IN(NI), .SCAN_TICKS(SCAN), .GAP_TICKS(GAP)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .key_in_i(key_in),
        .sleep_i(sleep), .sleep_drive_i(sleep_drive), .cs_i(cs),
        .rd_done_i(rd_done), .scan_o(scan), .key_data_o(key_data),
        .sleep_ack_o(sleep_ack), .req_n_o(req_n), .wake_o(wake)
    );

    // matrix model: a pressed key connects its drive line to its sense line
    always_comb begin
        key_in = '0;
        for (int l = 0; l < NO; l++)
            for (int i = 0; i < NI; i++)
                if (scan[l] && pressed[l*NI+i]) key_in[i] = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [KW-1:0] d, input logic a, input int at, input string tag);
        exp_t e;
        e.data = d; e.ack = a; e.at = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic wait_req();
        while (req_n) @(negedge clk);
    endtask

    task automatic readout();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    // monitor: each falling request is compared with the next expected item
    logic prev_req = 1'b1;
    logic prev_cs  = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        if (!rst && prev_req && !req_n && !prev_cs && !cs) begin
            if (q.size() == 0) begin
                check(1'b0, "R4 unexpected request", 32'(cyc), 32'hFFFFFFFF);
            end else begin
                e = q.pop_front();
                check(key_data == e.data, "R3 key data bits", 32'(key_data), 32'(e.data));
                check(sleep_ack == e.ack, "R9 sleep ack", 32'(sleep_ack), 32'(e.ack));
                check(cyc == e.at, e.tag, 32'(cyc), 32'(e.at));
            end
        end
        prev_req = req_n;
        prev_cs  = cs;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_n == 1'b1, "R1 req_n", 32'(req_n), 1);
        check(key_data == '0, "R1 key data", 32'(key_data), 0);
        check(sleep_ack == 1'b0, "R1 sleep ack", 32'(sleep_ack), 0);
        check(wake == 1'b0, "R1 wake", 32'(wake), 0);
        check(scan == 6'h3F, "R1 scan idle", 32'(scan), 32'h3F);

        // R2 nothing starts without keys
        repeat (10) @(negedge clk);
        check(scan == 6'h3F, "R2 idle pattern", 32'(scan), 32'h3F);
        check(req_n == 1'b1, "R2 no request", 32'(req_n), 1);

        // R3/R4 single key, line 0 input 0
        n = cyc;
        pressed = 30'h1;
        push_exp(30'h1, 1'b0, n + 1 + PAIR, "R4 request cycle");
        wait_cyc(n + 1);
        check(scan == 6'h01, "R3 line 0 first", 32'(scan), 32'h01);
        wait_cyc(n + 3);
        check(scan == 6'h02, "R3 line 1 next", 32'(scan), 32'h02);
        wait_cyc(n + 11);
        check(scan == 6'h20, "R3 line 5 last", 32'(scan), 32'h20);
        wait_req();
        // R8 release and readout: request clears, silent return to idle
        pressed = '0;
        readout();
        check(req_n == 1'b1, "R8 request cleared", 32'(req_n), 1);
        repeat (40) @(negedge clk);
        check(req_n == 1'b1, "R8 no request after release", 32'(req_n), 1);
        check(scan == 6'h3F, "R8 back to idle", 32'(scan), 32'h3F);

        // two keys: bit 29 (line 5 input 4) and bit 7 (line 1 input 2)
        n = cyc;
        pressed = (30'h1 << 29) | (30'h1 << 7);
        push_exp(pressed, 1'b0, n + 1 + PAIR, "R4 request cycle two keys");
        wait_req();
        pressed = pressed | (30'h1 << 12);
        repeat (5) @(negedge clk);
        check(key_data == ((30'h1 << 29) | (30'h1 << 7)), "R7 snapshot frozen",
              32'(key_data), 32'((30'h1 << 29) | (30'h1 << 7)));
        check(req_n == 1'b0, "R8 request held", 32'(req_n), 0);
        cs = 1'b1;
        #1;
        check(req_n == 1'b1, "R6 masked by select", 32'(req_n), 1);
        @(negedge clk);
        cs = 1'b0;
        #1;
        check(req_n == 1'b0, "R6 visible after select", 32'(req_n), 0);
        @(negedge clk);
        // R8 readout while keys still held raises a new request
        n = cyc;
        push_exp(pressed, 1'b0, n + 1 + PAIR, "R8 rescan request cycle");
        readout();
        wait_req();
        pressed = '0;
        readout();
        repeat (40) @(negedge clk);

        // R5 mismatch: key on line 5 added during the second scan
        n = cyc;
        pressed = 30'h1;
        push_exp(30'h1 | (30'h1 << 25), 1'b0, n + 1 + 2*PAIR, "R5 mismatch request cycle");
        wait_cyc(n + 15);
        pressed = pressed | (30'h1 << 25);
        wait_cyc(n + 1 + PAIR + 2);
        check(req_n == 1'b1, "R5 no request after mismatch", 32'(req_n), 1);
        wait_req();
        pressed = '0;
        readout();
        repeat (40) @(negedge clk);

        // R2/R9 low-power operation, only line 2 driven while idle
        sleep = 1'b1;
        sleep_drive = 6'b000100;
        @(negedge clk);
        check(scan == 6'h04, "R2 sleep idle pattern", 32'(scan), 32'h04);
        pressed = 30'h1;
        repeat (10) @(negedge clk);
        check(req_n == 1'b1, "R2 undriven key ignored", 32'(req_n), 1);
        check(wake == 1'b0, "R9 no wake on undriven key", 32'(wake), 0);
        check(scan == 6'h04, "R2 still idle", 32'(scan), 32'h04);
        n = cyc;
        pressed = 30'h1 | (30'h1 << 11);
        push_exp(30'h1 | (30'h1 << 11), 1'b1, n + 1 + PAIR, "R4 request cycle in sleep");
        wait_cyc(n + 1);
        check(wake == 1'b1, "R9 wake on key", 32'(wake), 1);
        wait_req();
        check(wake == 1'b1, "R9 wake while pending", 32'(wake), 1);
        pressed = '0;
        readout();
        repeat (40) @(negedge clk);
        check(wake == 1'b0, "R9 wake dropped in idle", 32'(wake), 0);
        check(sleep_ack == 1'b1, "R9 ack kept", 32'(sleep_ack), 1);
        check(scan == 6'h04, "R2 sleep idle again", 32'(scan), 32'h04);

        check(q.size() == 0, "R8 all requests seen", 32'(q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule